// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block decides which interrupt request a small single-issue processor core should service next. Two kinds of source feed it. Event sources raise a one-cycle strobe that is caught in a pending flag. Level sources request only while their input is high and keep no flag. Each source has its own enable bit, and one global enable gates all of them. The winning request goes to the core as a valid bit and a vector index. Priority is fixed by vector position. Index 0 is kept for reset and is never issued by this block, so event source 0 is the most urgent source that can be issued.

The core drives single-cycle handshake pulses back into the block:
- it accepted the vector;
- it executed a return from interrupt;
- it executed a global disable;
- it executed a global enable;
- it retired an instruction.

Taking a vector clears the global enable and clears the flag of the source that was taken. A return sets the global enable again, but no request is shown until at least one instruction has retired. A small register port lets software read and write the per-source enables, read the pending flags, and clear flags by writing ones.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, irq_valid_o is 0, the global enable is 0, and both registers read as zero: the enable register (reg_sel_i=0) and the flag register (reg_sel_i=1).
- R2: A high cycle on evt_i[k] sets pending flag k, which reads in bit k of the flag register from the next cycle. The flag stays set while it is masked, either by its own enable or by the global enable, until it is cleared.
- R3: irq_valid_o is 1 only when a source is requesting, that source's enable bit is 1 and the global enable is 1. Vector numbering:
  - event source k uses vector k+1;
  - level source j uses vector N_EDGE+1+j;
  - vector 0 is never issued.
- R4: When several sources are eligible, the lowest vector index is presented. Event sources rank above level sources.
- R5: A take_i pulse while irq_valid_o is 1 has two effects from the next cycle: the global enable is cleared, and the pending flag of the presented event source is cleared.
- R6: After an rti_i pulse, irq_valid_o stays 0 until a retire_i pulse has been seen in a later cycle. The rti_i pulse also sets the global enable.
- R7: A gena_i pulse sets the global enable from the next cycle.
- R8: While gdis_i is 1, irq_valid_o is 0 in that same cycle, even for a request that arrives in that cycle. The global enable is cleared from the next cycle.
- R9: Writing the flag register (reg_we_i=1, reg_sel_i=1) clears each flag whose data bit is 1. A data bit of 0 leaves that flag unchanged. An event in the same cycle as a clear or a take keeps its flag set.
- R10: Level sources have no flag and read as 0 in the flag register. They request only while lvl_i is high, so a level that drops before it is enabled causes no interrupt.
- R11: Writing the enable register (reg_we_i=1, reg_sel_i=0) stores all N_SRC enable bits, and they read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | N_EDGE | Event strobes, one per flagged source |
| lvl_i | input | N_LEVEL | Level requests, one per flagless source |
| irq_valid_o | output | 1 | A request is presented to the core |
| irq_vec_o | output | VEC_W | Vector index of the presented request (0 when none) |
| take_i | input | 1 | Core accepts the presented vector |
| rti_i | input | 1 | Core executed a return from interrupt |
| gdis_i | input | 1 | Core executed a global disable |
| gena_i | input | 1 | Core executed a global enable |
| retire_i | input | 1 | Core retired one instruction |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 enables, 1 flags |
| reg_wdata_i | input | N_SRC | Register write data |
| reg_rdata_o | output | N_SRC | Register read data for the selected register |

## Verification
The bench builds the block with four event sources and two level sources, so it has seven vector positions. This is enough to show an event source beating another event source, an event source beating a level source, and one level source beating the other. With two event flags pending at the same time, it can check that they are taken one after the other in priority order, with a return and a retire between them. It also covers the cycle-level cases: an event that lands on a clear, a global disable in the same cycle as a presented request, and a level that drops while masked.

// File: rtl/intc_pkg.sv
// Package: shared register-select encoding for the interrupt controller.
// Assumes a one-bit register select on the software port.
package intc_pkg;
    typedef enum logic {
        SEL_ENABLE = 1'b0,
        SEL_FLAGS  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/intc_flag_bank.sv
// Module: pending-flag storage for event-type sources.
// Each bit is set by an event strobe and cleared by a software
// write-one or a hardware take. An event always wins over a clear.
// Assumes clear inputs are single-cycle.
module intc_flag_bank #(
    parameter int N_EDGE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EDGE-1:0] evt_i,
    input  logic [N_EDGE-1:0] sw_clr_i,
    input  logic [N_EDGE-1:0] hw_clr_i,
    output logic [N_EDGE-1:0] flags_o
);
    for (genvar k = 0; k < N_EDGE; k++) begin : g_flag
        // Purpose: hold one pending flag; a new event beats any clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags_o[k] <= 1'b0;
            end else begin
                flags_o[k] <= evt_i[k] | (flags_o[k] & ~sw_clr_i[k] & ~hw_clr_i[k]);
            end
        end
    end
endmodule

// File: rtl/intc_prio_pick.sv
// Module: fixed-priority picker; the lowest set request index wins.
// Purely combinational. Assumes N >= 1.
module intc_prio_pick #(
    parameter int N     = 6,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    // Purpose: scan from the top down so the lowest set bit is the last one assigned.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/intc_global_gate.sv
// Module: global enable and the hold that follows a return.
// Take and disable clear the enable; a return or an enable command sets it.
// The hold is set by a return and released by a later retire pulse.
// Assumes all command inputs are single-cycle pulses.
module intc_global_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic take_ok_i,
    input  logic rti_i,
    input  logic gdis_i,
    input  logic gena_i,
    input  logic retire_i,
    output logic gie_o,
    output logic hold_o
);
    // Purpose: update the global enable; clearing commands win over setting ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_o <= 1'b0;
        end else if (take_ok_i || gdis_i) begin
            gie_o <= 1'b0;
        end else if (rti_i || gena_i) begin
            gie_o <= 1'b1;
        end
    end

    // Purpose: block presentation after a return until one instruction retires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_o <= 1'b0;
        end else if (rti_i) begin
            hold_o <= 1'b1;
        end else if (retire_i) begin
            hold_o <= 1'b0;
        end
    end
endmodule

// File: rtl/prio_vec_intc.sv
// Module: prioritized vectored interrupt controller (top).
// Combines event flags and level inputs with the per-source enables.
// Presents the lowest-index eligible source as vector index+1, because
// slot 0 is kept for reset. Outputs are combinational from state and inputs.
// Assumes the core raises take_i only while irq_valid_o is 1.
module prio_vec_intc #(
    parameter  int N_EDGE  = 4,
    parameter  int N_LEVEL = 2,
    localparam int N_SRC   = N_EDGE + N_LEVEL,
    localparam int VEC_W   = $clog2(N_SRC + 1),
    localparam int IDX_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_EDGE-1:0]  evt_i,
    input  logic [N_LEVEL-1:0] lvl_i,
    output logic               irq_valid_o,
    output logic [VEC_W-1:0]   irq_vec_o,
    input  logic               take_i,
    input  logic               rti_i,
    input  logic               gdis_i,
    input  logic               gena_i,
    input  logic               retire_i,
    input  logic               reg_we_i,
    input  logic               reg_sel_i,
    input  logic [N_SRC-1:0]   reg_wdata_i,
    output logic [N_SRC-1:0]   reg_rdata_o
);
    import intc_pkg::*;

    logic [N_SRC-1:0]  enables;
    logic [N_EDGE-1:0] flags;
    logic [N_EDGE-1:0] sw_clr;
    logic [N_EDGE-1:0] hw_clr;
    logic [N_SRC-1:0]  req;
    logic              any_req;
    logic [IDX_W-1:0]  win_idx;
    logic              gie;
    logic              hold;
    logic              take_ok;

    // Purpose: software-written enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enables <= '0;
        end else if (reg_we_i && reg_sel_e'(reg_sel_i) == SEL_ENABLE) begin
            enables <= reg_wdata_i;
        end
    end

    // Purpose: write-one-to-clear mask for the flag register.
    always_comb begin
        sw_clr = '0;
        if (reg_we_i && reg_sel_e'(reg_sel_i) == SEL_FLAGS) begin
            sw_clr = reg_wdata_i[N_EDGE-1:0];
        end
    end

    assign take_ok = take_i && irq_valid_o;

    // Purpose: clear only the flag of the event source being taken.
    for (genvar k = 0; k < N_EDGE; k++) begin : g_hwclr
        assign hw_clr[k] = take_ok && (win_idx == IDX_W'(k));
    end

    intc_flag_bank #(.N_EDGE(N_EDGE)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .sw_clr_i (sw_clr),
        .hw_clr_i (hw_clr),
        .flags_o  (flags)
    );

    // Purpose: eligible requests; event flags take the low positions.
    assign req = {lvl_i, flags} & enables;

    intc_prio_pick #(.N(N_SRC)) u_pick (
        .req_i (req),
        .any_o (any_req),
        .idx_o (win_idx)
    );

    intc_global_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_ok_i (take_ok),
        .rti_i     (rti_i),
        .gdis_i    (gdis_i),
        .gena_i    (gena_i),
        .retire_i  (retire_i),
        .gie_o     (gie),
        .hold_o    (hold)
    );

    // Purpose: present the winner only when globally open and not disabled this cycle.
    always_comb begin
        irq_valid_o = any_req && gie && !hold && !gdis_i;
        irq_vec_o   = irq_valid_o ? (VEC_W'(win_idx) + VEC_W'(1)) : '0;
    end

    // Purpose: read mux; level sources read as zero in the flag register.
    always_comb begin
        if (reg_sel_e'(reg_sel_i) == SEL_FLAGS) begin
            reg_rdata_o = {{N_LEVEL{1'b0}}, flags};
        end else begin
            reg_rdata_o = enables;
        end
    end
endmodule

// Module: assertion checker bound to the controller top.
// Watches ports and the flag and gate state across cycles.
module intc_checker #(
    parameter int N_EDGE = 4,
    parameter int N_SRC  = 6,
    parameter int VEC_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_EDGE-1:0] evt_i,
    input logic              irq_valid_o,
    input logic [VEC_W-1:0]  irq_vec_o,
    input logic              take_i,
    input logic              rti_i,
    input logic              gdis_i,
    input logic              gena_i,
    input logic              reg_we_i,
    input logic              reg_sel_i,
    input logic [N_EDGE-1:0] flags,
    input logic              gie,
    input logic              hold
);
    assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(take_i && irq_valid_o) && !(reg_we_i && reg_sel_i))
        |=> ((flags & $past(flags)) == $past(flags)));

    assert_valid_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> (gie && !hold));

    assert_vec_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> (irq_vec_o != '0 && int'(irq_vec_o) <= N_SRC));

    assert_take_masks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && irq_valid_o) |=> (!gie && !irq_valid_o));

    assert_rti_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rti_i |=> !irq_valid_o);

    assert_gena_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gena_i && !gdis_i && !(take_i && irq_valid_o)) |=> gie);

    assert_gdis_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gdis_i |-> !irq_valid_o);

    assert_evt_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((flags & $past(evt_i)) == $past(evt_i)));
endmodule

bind prio_vec_intc intc_checker #(
    .N_EDGE (N_EDGE),
    .N_SRC  (N_SRC),
    .VEC_W  (VEC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .irq_valid_o (irq_valid_o),
    .irq_vec_o   (irq_vec_o),
    .take_i      (take_i),
    .rti_i       (rti_i),
    .gdis_i      (gdis_i),
    .gena_i      (gena_i),
    .reg_we_i    (reg_we_i),
    .reg_sel_i   (reg_sel_i),
    .flags       (flags),
    .gie         (gie),
    .hold        (hold)
);

// File: tb/tb_prio_vec_intc.sv
`timescale 1ns/100ps
module tb_prio_vec_intc;
    localparam int NE = 4;
    localparam int NL = 2;
    localparam int NS = NE + NL;
    localparam int VW = $clog2(NS + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] evt_i = '0;
    logic [NL-1:0] lvl_i = '0;
    logic          irq_valid_o;
    logic [VW-1:0] irq_vec_o;
    logic          take_i = 1'b0, rti_i = 1'b0, gdis_i = 1'b0, gena_i = 1'b0, retire_i = 1'b0;
    logic          reg_we_i = 1'b0, reg_sel_i = 1'b0;
    logic [NS-1:0] reg_wdata_i = '0;
    logic [NS-1:0] reg_rdata_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        bit        is_reg;
        bit        valid;
        int        data;
        string     tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    prio_vec_intc #(.N_EDGE(NE), .N_LEVEL(NL)) dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .lvl_i(lvl_i),
        .irq_valid_o(irq_valid_o), .irq_vec_o(irq_vec_o),
        .take_i(take_i), .rti_i(rti_i), .gdis_i(gdis_i), .gena_i(gena_i),
        .retire_i(retire_i), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o)
    );

    // Monitor: pops expected items and compares them with the outputs.
    initial begin
        exp_t it;
        forever begin
            wait (sb.size() > 0);
            it = sb.pop_front();
            tests++;
            if (it.is_reg) begin
                if (int'(reg_rdata_o) != it.data) begin
                    fails++;
                    $display("FAIL %s: rdata actual=%0h expected=%0h", it.tag, reg_rdata_o, it.data);
                end
            end else if (irq_valid_o != it.valid || (it.valid && int'(irq_vec_o) != it.data)) begin
                fails++;
                $display("FAIL %s: valid/vec actual=%0b/%0d expected=%0b/%0d",
                         it.tag, irq_valid_o, irq_vec_o, it.valid, it.data);
            end
        end
    end

    // Advance one cycle; pulse inputs return to zero after the edge.
    task automatic step();
        @(posedge clk);
        #1;
        evt_i = '0; take_i = 0; rti_i = 0; gdis_i = 0; gena_i = 0; retire_i = 0; reg_we_i = 0;
    endtask

    task automatic wr(input bit sel, input int data);
        reg_we_i = 1; reg_sel_i = sel; reg_wdata_i = NS'(data);
        step();
    endtask

    task automatic exp_irq(input bit v, input int vec, input string tag);
        exp_t it;
        it.is_reg = 0; it.valid = v; it.data = vec; it.tag = tag;
        #0.2;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic exp_reg(input bit sel, input int data, input string tag);
        exp_t it;
        reg_sel_i = sel;
        it.is_reg = 1; it.valid = 0; it.data = data; it.tag = tag;
        #0.2;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        step(); step();
        exp_irq(0, 0, "R1 reset valid");
        exp_reg(0, 0, "R1 reset enables");
        exp_reg(1, 0, "R1 reset flags");
        rst_n = 1; step();

        wr(0, 'h2D);
        exp_reg(0, 'h2D, "R11 enable readback");
        wr(0, 0);
        exp_reg(0, 0, "R11 enable cleared");

        evt_i = 4'b0100; step();
        exp_reg(1, 'h04, "R2 flag set");
        exp_irq(0, 0, "R2 masked no request");
        step(); step();
        exp_reg(1, 'h04, "R2 flag stays while masked");

        wr(1, 0);
        exp_reg(1, 'h04, "R9 write zero keeps flag");
        wr(1, 'h04);
        exp_reg(1, 0, "R9 write one clears flag");
        evt_i = 4'b0010; reg_we_i = 1; reg_sel_i = 1; reg_wdata_i = NS'('h02); step();
        exp_reg(1, 'h02, "R9 event beats clear");
        wr(1, 'h02);
        exp_reg(1, 0, "R9 flag cleared");

        evt_i = 4'b1010; step();
        wr(0, 'h3F);
        exp_irq(0, 0, "R3 global enable off");
        gena_i = 1; step();
        exp_irq(1, 2, "R7 R4 lowest event vector");

        gdis_i = 1;
        exp_irq(0, 0, "R8 disable same cycle");
        step();
        exp_irq(0, 0, "R8 disable cleared global");
        gena_i = 1; step();
        exp_irq(1, 2, "R7 re-enabled");

        take_i = 1; step();
        exp_irq(0, 0, "R5 take masks");
        exp_reg(1, 'h08, "R5 taken flag cleared");

        rti_i = 1; step();
        exp_irq(0, 0, "R6 hold after return");
        step();
        exp_irq(0, 0, "R6 still held without retire");
        retire_i = 1; step();
        exp_irq(1, 4, "R6 R2 next pending after retire");

        take_i = 1; step();
        exp_reg(1, 0, "R5 second flag cleared");
        rti_i = 1; step();
        retire_i = 1; step();
        exp_irq(0, 0, "R3 nothing pending");

        lvl_i = 2'b10; #0.1;
        exp_irq(1, 6, "R10 level source vector");
        exp_reg(1, 0, "R10 level has no flag");
        lvl_i = 2'b00;
        exp_irq(0, 0, "R10 level dropped");
        lvl_i = 2'b11;
        exp_irq(1, 5, "R4 lower level wins");
        evt_i = 4'b0001; step();
        exp_irq(1, 1, "R4 event above level");
        wr(1, 'h01);
        lvl_i = 2'b00;
        exp_irq(0, 0, "R9 R10 all cleared");

        wr(0, 0);
        lvl_i = 2'b01; step();
        lvl_i = 2'b00; step();
        wr(0, 'h3F);
        exp_irq(0, 0, "R10 level dropped before enable");

        wr(0, 'h3E);
        evt_i = 4'b0001; step();
        exp_irq(0, 0, "R3 local mask blocks");
        exp_reg(1, 'h01, "R2 flag kept under local mask");
        wr(0, 'h3F);
        exp_irq(1, 1, "R3 local enable releases");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule